// File: doc/BRIEF.md
# Cascade Bus Role and Slave Selection

This block lets one interrupt controller be chained to further controllers of the same kind over a 3-bit cascade bus. A strap input fixes the role of each chip. A master that grants an interrupt input with a slave behind it broadcasts that input's index on the bus. A slave compares what it sees on the bus against its own programmed identity, and it claims the vector phase only when the two match. With a 3-bit bus, one master can select among eight slaves, which gives up to 64 vectored request lines.

An acknowledge sequence is two pulses on the `ack` strobe. The block counts the pulses with a small phase tracker: idle, first pulse, gap, second pulse. A master drives the bus only while such a sequence is open. When the granted master input has no slave attached, or when no input was granted, the bus stays released and the master enables its own vector output instead. Bus direction is split into `cas_in`, `cas_out` and `cas_oe`, and the pad is left outside the block. Priority resolution and the vector value are produced elsewhere.

Top module: `casc_link`

## Requirements
- R1: During reset and directly after it, `cas_oe`, `cas_out` and `vec_oe` are all 0.
- R2: The clock edge that first samples `ack` high while idle opens a sequence. The edge that samples it low ends the first pulse. The next high sample opens the second pulse. The low sample after that closes the sequence.
- R3: If `master_strap`=1 and, at the opening edge, `win_valid`=1 and `slave_map[win_idx]`=1, then `cas_oe`=1 and `cas_out` equals the `win_idx` captured at that edge. This holds from the cycle after the opening edge until the closing edge. Later changes of `win_idx` have no effect within the sequence.
- R4: If `master_strap`=1 and, at the opening edge, either `win_valid`=0 or `slave_map[win_idx]`=0, then `cas_oe` stays 0 and `vec_oe`=1 for the whole second-pulse phase.
- R5: Whenever `cas_oe`=0, `cas_out` is 0.
- R6: With `master_strap`=0, `cas_oe` is never 1.
- R7: With `master_strap`=0, `cas_in` is sampled at the edge that opens the second pulse. If it equals `my_id`, `vec_oe`=1 for the whole second-pulse phase. Changes of `cas_in` after that edge have no effect.
- R8: With `master_strap`=0 and `cas_in`≠`my_id` at that edge, `vec_oe` stays 0 during both pulses. This holds even if the two matched during the first pulse.
- R9: `vec_oe` is 1 only in the second-pulse phase, in either role.
- R10: A master that has a slave on its granted input keeps `vec_oe` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_strap | input | 1 | 1 selects master, 0 selects slave |
| ack | input | 1 | Acknowledge strobe, active high, two pulses per sequence |
| win_valid | input | 1 | An input won arbitration |
| win_idx | input | 3 | Index of the winning input |
| slave_map | input | 8 | Bit i set: a slave is attached to input i |
| my_id | input | 3 | Programmed slave identity |
| cas_in | input | 3 | Cascade bus as seen at the pins |
| cas_out | output | 3 | Cascade value driven by a master |
| cas_oe | output | 1 | Cascade output enable |
| vec_oe | output | 1 | Enable for this chip's vector output |

## Verification
The most delicate case is a slave that sees its own identity on the bus at the wrong time. For example, the bus matches during the first pulse but holds a different value at the edge that opens the second pulse, or the match ends just after that edge. The stimulus drives `cas_in` independently of the block, moves it between pulses and inside the second pulse, and so reaches both timings. On the master side, `win_idx` is changed while the first pulse is still high, to show that the broadcast identity is the one captured at the opening edge.

// File: rtl/casc_pkg.sv
package casc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_GAP    = 2'd2,
    PH_SECOND = 2'd3
  } ack_phase_e;

  // Next phase of the two-pulse acknowledge sequence.
  function automatic ack_phase_e next_phase(input ack_phase_e cur, input logic ack);
    ack_phase_e nxt;
    nxt = cur;
    case (cur)
      PH_IDLE:   if (ack)  nxt = PH_FIRST;
      PH_FIRST:  if (!ack) nxt = PH_GAP;
      PH_GAP:    if (ack)  nxt = PH_SECOND;
      PH_SECOND: if (!ack) nxt = PH_IDLE;
      default:   nxt = PH_IDLE;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/casc_ack_seq.sv
module casc_ack_seq
  import casc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ack,
  output ack_phase_e phase,
  output logic       open_evt,
  output logic       second_evt
);

  ack_phase_e phase_q;

  assign phase      = phase_q;
  assign open_evt   = (phase_q == PH_IDLE) && ack;
  assign second_evt = (phase_q == PH_GAP) && ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= next_phase(phase_q, ack);
  end

  // R2
  open_to_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_evt |=> (phase == PH_FIRST));

  // R2
  gap_to_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    second_evt |=> (phase == PH_SECOND));

  // R2
  idle_no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |=> (phase == PH_IDLE || phase == PH_FIRST));

endmodule

// File: rtl/casc_master_drv.sv
module casc_master_drv
  import casc_pkg::*;
#(
  parameter int ID_W = 3,
  localparam int N_IN = 1 << ID_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            is_master,
  input  logic            open_evt,
  input  ack_phase_e      phase,
  input  logic            win_valid,
  input  logic [ID_W-1:0] win_idx,
  input  logic [N_IN-1:0] slave_map,
  output logic [ID_W-1:0] cas_out,
  output logic            cas_oe,
  output logic            self_vec
);

  function automatic logic slave_behind(input logic valid,
                                        input logic [ID_W-1:0] idx,
                                        input logic [N_IN-1:0] map);
    return valid && map[idx];
  endfunction

  logic            hit_q;
  logic [ID_W-1:0] id_q;
  logic            seq_open;

  assign seq_open = (phase != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      id_q  <= '0;
    end else if (open_evt) begin
      hit_q <= slave_behind(win_valid, win_idx, slave_map);
      id_q  <= win_idx;
    end
  end

  assign cas_oe   = is_master && seq_open && hit_q;
  assign cas_out  = cas_oe ? id_q : '0;
  assign self_vec = is_master && (phase == PH_SECOND) && !hit_q;

  // R3
  id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_oe && $past(cas_oe)) |-> $stable(cas_out));

  // R5
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_oe |-> (cas_out == '0));

  // R10
  drive_or_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cas_oe && self_vec));

endmodule

// File: rtl/casc_slave_sel.sv
module casc_slave_sel
  import casc_pkg::*;
#(
  parameter int ID_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            is_master,
  input  logic            second_evt,
  input  ack_phase_e      phase,
  input  logic [ID_W-1:0] cas_in,
  input  logic [ID_W-1:0] my_id,
  output logic            claim
);

  function automatic logic id_equal(input logic [ID_W-1:0] a,
                                    input logic [ID_W-1:0] b);
    return (a ^ b) == '0;
  endfunction

  logic match_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          match_q <= 1'b0;
    else if (second_evt) match_q <= id_equal(cas_in, my_id);
  end

  assign claim = !is_master && (phase == PH_SECOND) && match_q;

  // R8
  claim_in_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    claim |-> (phase == PH_SECOND));

  // R7
  match_claims_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (second_evt && !is_master && (cas_in == my_id)) |=> (claim || is_master));

endmodule

// File: rtl/casc_link.sv
module casc_link
  import casc_pkg::*;
#(
  parameter int ID_W = 3,
  localparam int N_IN = 1 << ID_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            master_strap,
  input  logic            ack,
  input  logic            win_valid,
  input  logic [ID_W-1:0] win_idx,
  input  logic [N_IN-1:0] slave_map,
  input  logic [ID_W-1:0] my_id,
  input  logic [ID_W-1:0] cas_in,
  output logic [ID_W-1:0] cas_out,
  output logic            cas_oe,
  output logic            vec_oe
);

  ack_phase_e phase;
  logic       open_evt;
  logic       second_evt;
  logic       self_vec;
  logic       slave_claim;

  casc_ack_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack        (ack),
    .phase      (phase),
    .open_evt   (open_evt),
    .second_evt (second_evt)
  );

  casc_master_drv #(.ID_W(ID_W)) u_mdrv (
    .clk       (clk),
    .rst_n     (rst_n),
    .is_master (master_strap),
    .open_evt  (open_evt),
    .phase     (phase),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .slave_map (slave_map),
    .cas_out   (cas_out),
    .cas_oe    (cas_oe),
    .self_vec  (self_vec)
  );

  casc_slave_sel #(.ID_W(ID_W)) u_ssel (
    .clk        (clk),
    .rst_n      (rst_n),
    .is_master  (master_strap),
    .second_evt (second_evt),
    .phase      (phase),
    .cas_in     (cas_in),
    .my_id      (my_id),
    .claim      (slave_claim)
  );

  assign vec_oe = master_strap ? self_vec : slave_claim;

  // R6
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_strap |-> !cas_oe);

  // R9
  vec_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe |-> (phase == PH_SECOND));

endmodule

// File: tb/casc_link_tb.sv
module casc_link_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       master_strap = 1'b1;
  logic       ack = 1'b0;
  logic       win_valid = 1'b0;
  logic [2:0] win_idx = '0;
  logic [7:0] slave_map = 8'b1010_0100;
  logic [2:0] my_id = 3'd5;
  logic [2:0] cas_in = '0;
  logic [2:0] cas_out;
  logic       cas_oe;
  logic       vec_oe;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";
  bit cmp_on = 1'b0;

  // behavioural reference state
  int m_phase = 0;
  bit m_hit = 0;
  int m_id = 0;
  bit m_match = 0;

  always #4 clk = ~clk;

  casc_link u_dut (
    .clk(clk), .rst_n(rst_n), .master_strap(master_strap), .ack(ack),
    .win_valid(win_valid), .win_idx(win_idx), .slave_map(slave_map),
    .my_id(my_id), .cas_in(cas_in), .cas_out(cas_out), .cas_oe(cas_oe),
    .vec_oe(vec_oe)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_hit = 0; m_id = 0; m_match = 0;
    end else begin
      if (m_phase == 0) begin
        if (ack) begin
          m_phase = 1;
          m_hit = win_valid && slave_map[win_idx];
          m_id = int'(win_idx);
        end
      end else if (m_phase == 1) begin
        if (!ack) m_phase = 2;
      end else if (m_phase == 2) begin
        if (ack) begin
          m_phase = 3;
          m_match = (cas_in == my_id);
        end
      end else begin
        if (!ack) m_phase = 0;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (cmp_on) begin
      int e_oe, e_out, e_vec;
      if (master_strap) begin
        e_oe  = (m_phase != 0 && m_hit) ? 1 : 0;
        e_out = e_oe ? m_id : 0;
        e_vec = (m_phase == 3 && !m_hit) ? 1 : 0;
      end else begin
        e_oe  = 0;
        e_out = 0;
        e_vec = (m_phase == 3 && m_match) ? 1 : 0;
      end
      check(cur_req, int'(cas_oe), e_oe, "cas_oe");
      check(cur_req, int'(cas_out), e_out, "cas_out");
      check(cur_req, int'(vec_oe), e_vec, "vec_oe");
      if (!cas_oe) check("R5", int'(cas_out), 0, "cas_out while released");
      if (!master_strap) check("R6", int'(cas_oe), 0, "slave cas_oe");
      if (vec_oe) check("R9", m_phase, 3, "phase while vec_oe");
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ack_seq(input int hi1, input int gap, input int hi2);
    @(negedge clk) ack = 1'b1;
    idle(hi1);
    ack = 1'b0;
    idle(gap);
    ack = 1'b1;
    idle(hi2);
    ack = 1'b0;
    idle(3);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3);
    // R1: outputs quiet in reset
    check("R1", int'(cas_oe), 0, "cas_oe in reset");
    check("R1", int'(vec_oe), 0, "vec_oe in reset");
    check("R1", int'(cas_out), 0, "cas_out in reset");
    rst_n = 1'b1;
    cmp_on = 1'b1;
    idle(3);

    // R3 / R10: master, slave on input 2, index moved during first pulse
    cur_req = "R3";
    win_valid = 1'b1; win_idx = 3'd2;
    @(negedge clk) ack = 1'b1;
    idle(1);
    win_idx = 3'd7;
    idle(2);
    ack = 1'b0;
    idle(3);
    ack = 1'b1;
    #6 check("R3", int'(cas_out), 2, "captured id during second pulse");
    check("R10", int'(vec_oe), 0, "master with slave vec_oe");
    idle(2);
    ack = 1'b0;
    idle(3);

    // R2: short pulses, one-cycle gap
    cur_req = "R2";
    win_idx = 3'd7;
    ack_seq(1, 1, 1);
    ack_seq(4, 6, 5);

    // R4: no slave on input 3
    cur_req = "R4";
    win_idx = 3'd3;
    ack_seq(2, 2, 3);
    // R4: nothing granted, although input 5 has a slave
    win_valid = 1'b0; win_idx = 3'd5;
    ack_seq(1, 3, 2);

    // R7: slave, bus matches at second-pulse edge, then moves
    master_strap = 1'b0;
    cur_req = "R7";
    cas_in = 3'd5;
    @(negedge clk) ack = 1'b1;
    idle(2);
    ack = 1'b0;
    idle(2);
    ack = 1'b1;
    idle(1);
    cas_in = 3'd0;
    #6 check("R7", int'(vec_oe), 1, "slave claim after bus change");
    idle(2);
    ack = 1'b0;
    idle(3);

    // R8: mismatch throughout
    cur_req = "R8";
    cas_in = 3'd4;
    ack_seq(2, 2, 3);
    // R8: matches during first pulse only
    cas_in = 3'd5;
    @(negedge clk) ack = 1'b1;
    idle(2);
    ack = 1'b0;
    cas_in = 3'd1;
    idle(2);
    ack = 1'b1;
    idle(1);
    cas_in = 3'd5;
    #6 check("R8", int'(vec_oe), 0, "late match ignored");
    idle(2);
    ack = 1'b0;
    idle(3);

    // R7: another identity
    cur_req = "R7";
    my_id = 3'd0; cas_in = 3'd0;
    ack_seq(1, 1, 2);

    idle(4);
    finish_run();
  end

endmodule